// File: doc/BRIEF.md
# Fuse Array Shadow-Read Sequencer

This block drives the pins of a 32-word by 32-bit one-time-programmable fuse array on behalf of an APB slave. After reset it walks the array's read protocol by itself. It opens a session with chip select high, then pulls chip select low while raising load and program-enable. Each word then gets an address phase, a strobe-high phase and a strobe-low phase. A tail interval follows, then chip select is raised to close the session. Every captured word is stored in an internal shadow buffer. Every step lasts a fixed, parameterised number of clock cycles, so no pin moves before its settle interval has run out.

Once the automatic read-out has finished, software can read any shadow word over APB. This includes the three leakage trim words at indices 23, 24 and 25. Software can also drive the fuse pins itself through a manual control register and sample the array's data output live. APB access is honoured only while the security-select input is high.

Top module: `fuse_shadow_reader`

## Requirements
- R1: While reset is held and during the first settle interval after it, fz_csn is 1; fz_strobe, fz_load and fz_pgm_en are 0; fz_addr is 0; rd_busy is 1 and rd_done is 0.
- R2: In the second settle interval, fz_csn is 0, fz_load and fz_pgm_en are 1, fz_strobe is 0 and fz_addr is 0.
- R3: Each word takes three settle intervals in turn. First the address is held with strobe low, then strobe is high, then strobe is low again. The word is captured from fz_dout at the last cycle of the strobe-high interval.
- R4: Words are visited in ascending order from 0 to 31, and the sequencer never drives an address above 31.
- R5: After word 31, one more interval keeps fz_csn low. Then fz_csn is 1 for one interval with load and program-enable still high. After that, rd_busy falls, rd_done rises and rd_done stays high.
- R6: An APB read at byte offset 0x100 + 4*i, for i from 0 to 31, returns shadow word i with pslverr 0. This covers the leakage words 23, 24 and 25.
- R7: An APB access at byte offset 0x180 to 0x1FC, which maps to a shadow index from 32 to 63, returns prdata 0 with pslverr 1.
- R8: While sec_sel is 0, every APB access completes with pslverr 1 and prdata 0, and a control write has no effect.
- R9: The control register at offset 0x0 resets to 0x1. Its fields are: bit 0 chip select (active low), bit 1 strobe, bit 2 load, bit 3 program-enable, and bits 15:6 the address. Reads return the written value masked to those bits. When idle, the fuse pins follow those fields from the edge that ends the write.
- R10: A read at offset 0x4 returns the present fz_dout value.
- R11: Control writes made while rd_busy is 1 are ignored.
- R12: pready is 1 on every access, so every transfer has zero wait states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_sel | input | 1 | Security select; APB access allowed when high |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write when high |
| paddr | input | PADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | APB ready, always high |
| pslverr | output | 1 | APB error response |
| fz_csn | output | 1 | Fuse chip select, active low |
| fz_strobe | output | 1 | Fuse read strobe |
| fz_load | output | 1 | Fuse load enable |
| fz_pgm_en | output | 1 | Fuse program-enable, high for reads |
| fz_addr | output | FA_W | Fuse word address |
| fz_dout | input | DATA_W | Fuse data output |
| rd_busy | output | 1 | Automatic read-out in progress |
| rd_done | output | 1 | Automatic read-out complete (sticky) |

## Verification
The pins and the two status flags are registered decodes of the sequencer state. After n clock edges since reset release they are therefore a pure function of n / SETTLE_CYC. The bench samples them one time unit after every falling edge and compares them with that function for the whole session and a few idle cycles beyond it. APB read data and pslverr are combinational in the access phase, so they are sampled in that phase before the completing edge. A control write reaches the pins at the edge that completes the access, so the pins are checked at the following falling edge.

// File: rtl/fzr_pkg.sv
package fzr_pkg;

   typedef enum logic [2:0] {
      ST_BOOT  = 3'd0,
      ST_OPEN  = 3'd1,
      ST_ADDR  = 3'd2,
      ST_STRB  = 3'd3,
      ST_LOW   = 3'd4,
      ST_TAIL  = 3'd5,
      ST_CLOSE = 3'd6,
      ST_IDLE  = 3'd7
   } seq_st_e;

   typedef struct packed {
      logic csn;
      logic strobe;
      logic load;
      logic pgm_en;
   } fz_pins_t;

   localparam int CTRL_CSN_BIT  = 0;
   localparam int CTRL_STB_BIT  = 1;
   localparam int CTRL_LD_BIT   = 2;
   localparam int CTRL_PGM_BIT  = 3;
   localparam int CTRL_ADDR_LSB = 6;

endpackage

// File: rtl/fzr_settle_timer.sv
module fzr_settle_timer #(
   parameter int CYC = 400
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = $clog2(CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(CYC - 1);

   logic [CW-1:0] cnt_q;

   if (CYC < 1) begin : g_bad_cyc
      $error("fzr_settle_timer: CYC must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (!en)            cnt_q <= '0;
      else if (cnt_q == LAST)  cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   assign tick = en && (cnt_q == LAST);

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);

endmodule

// File: rtl/fzr_read_seq.sv
module fzr_read_seq
   import fzr_pkg::*;
#(
   parameter int WORDS      = 32,
   parameter int IDX_W      = 5,
   parameter int DATA_W     = 32,
   parameter int FA_W       = 10,
   parameter int SETTLE_CYC = 400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] fz_dout,
   output fz_pins_t          pins,
   output logic [FA_W-1:0]   addr,
   output logic              busy,
   output logic              done,
   output logic              cap_en,
   output logic [IDX_W-1:0]  cap_idx,
   output logic [DATA_W-1:0] cap_data
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORDS - 1);

   seq_st_e          state_q, state_d;
   logic [IDX_W-1:0] idx_q;
   logic             done_q;
   logic             tick;

   fzr_settle_timer #(.CYC(SETTLE_CYC)) u_tmr (
      .clk  (clk),
      .rst_n(rst_n),
      .en   (state_q != ST_IDLE),
      .tick (tick)
   );

   always_comb begin
      state_d = state_q;
      if (tick) begin
         unique case (state_q)
            ST_BOOT:  state_d = ST_OPEN;
            ST_OPEN:  state_d = ST_ADDR;
            ST_ADDR:  state_d = ST_STRB;
            ST_STRB:  state_d = ST_LOW;
            ST_LOW:   state_d = (idx_q == LAST_IDX) ? ST_TAIL : ST_ADDR;
            ST_TAIL:  state_d = ST_CLOSE;
            ST_CLOSE: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_BOOT;
         idx_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         if (tick && state_q == ST_LOW && idx_q != LAST_IDX)
            idx_q <= idx_q + 1'b1;
         if (tick && state_q == ST_CLOSE)
            done_q <= 1'b1;
      end
   end

   always_comb begin
      pins.csn    = (state_q == ST_BOOT) || (state_q == ST_CLOSE) || (state_q == ST_IDLE);
      pins.load   = (state_q != ST_BOOT) && (state_q != ST_IDLE);
      pins.pgm_en = (state_q != ST_BOOT) && (state_q != ST_IDLE);
      pins.strobe = (state_q == ST_STRB);
   end

   assign addr     = FA_W'(idx_q);
   assign busy     = (state_q != ST_IDLE);
   assign done     = done_q;
   assign cap_en   = tick && (state_q == ST_STRB);
   assign cap_idx  = idx_q;
   assign cap_data = fz_dout;

   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && !tick) |=> ($stable(state_q) && $stable(idx_q)));

   p_idx_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
      idx_q <= LAST_IDX);

   p_idx_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (idx_q != $past(idx_q)) |-> (idx_q == $past(idx_q) + 1'b1));

   p_done_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> (done_q && state_q == ST_IDLE));

endmodule

// File: rtl/fzr_shadow_buf.sv
module fzr_shadow_buf #(
   parameter int WORDS  = 32,
   parameter int IDX_W  = 5,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data
);
   logic [DATA_W-1:0] mem_q [WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
      end else if (wr_en) begin
         for (int w = 0; w < WORDS; w++)
            if (wr_idx == IDX_W'(w)) mem_q[w] <= wr_data;
      end
   end

   if (WORDS == (1 << IDX_W)) begin : g_full
      assign rd_data = mem_q[rd_idx];
   end else begin : g_partial
      assign rd_data = (int'(rd_idx) < WORDS) ? mem_q[rd_idx] : '0;
   end

   p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < WORDS));

endmodule

// File: rtl/fzr_apb_regs.sv
module fzr_apb_regs
   import fzr_pkg::*;
#(
   parameter int WORDS       = 32,
   parameter int IDX_W       = 5,
   parameter int DATA_W      = 32,
   parameter int FA_W        = 10,
   parameter int PADDR_W     = 12,
   parameter int SHADOW_BASE = 'h100
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_sel,
   input  logic               busy,
   input  logic               psel,
   input  logic               penable,
   input  logic               pwrite,
   input  logic [PADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0]  pwdata,
   output logic [DATA_W-1:0]  prdata,
   output logic               pready,
   output logic               pslverr,
   input  logic [DATA_W-1:0]  fz_dout,
   input  logic [DATA_W-1:0]  shadow_data,
   output logic [IDX_W-1:0]   shadow_idx,
   output fz_pins_t           man_pins,
   output logic [FA_W-1:0]    man_addr
);
   localparam logic [DATA_W-1:0] CTRL_MASK =
      (DATA_W'((1 << FA_W) - 1) << CTRL_ADDR_LSB) | DATA_W'(4'hF);
   localparam logic [DATA_W-1:0] CTRL_RST = DATA_W'(1);
   localparam int WIN_HI_W = PADDR_W - 8;
   localparam logic [WIN_HI_W-1:0] WIN_TAG = WIN_HI_W'(SHADOW_BASE >> 8);

   logic [DATA_W-1:0] ctrl_q;
   logic              access, in_win, is_ctrl, is_dout, slot_ok;
   logic [5:0]        slot;

   assign access  = psel && penable;
   assign slot    = paddr[7:2];
   assign in_win  = (paddr[PADDR_W-1:8] == WIN_TAG) && (paddr[1:0] == 2'b00);
   assign is_ctrl = (paddr == PADDR_W'(0));
   assign is_dout = (paddr == PADDR_W'(4));

   if (WORDS == 64) begin : g_slot_all
      assign slot_ok = 1'b1;
   end else begin : g_slot_cmp
      assign slot_ok = (int'(slot) < WORDS);
   end

   assign shadow_idx = slot[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ctrl_q <= CTRL_RST;
      else if (access && pwrite && sec_sel && !busy && is_ctrl)
         ctrl_q <= pwdata & CTRL_MASK;
   end

   always_comb begin
      prdata  = '0;
      pslverr = 1'b0;
      if (access) begin
         if (!sec_sel)
            pslverr = 1'b1;
         else if (in_win && !slot_ok)
            pslverr = 1'b1;
         else if (!pwrite) begin
            if (in_win)       prdata = shadow_data;
            else if (is_ctrl) prdata = ctrl_q;
            else if (is_dout) prdata = fz_dout;
         end
      end
   end

   assign pready          = 1'b1;
   assign man_pins.csn    = ctrl_q[CTRL_CSN_BIT];
   assign man_pins.strobe = ctrl_q[CTRL_STB_BIT];
   assign man_pins.load   = ctrl_q[CTRL_LD_BIT];
   assign man_pins.pgm_en = ctrl_q[CTRL_PGM_BIT];
   assign man_addr        = ctrl_q[CTRL_ADDR_LSB +: FA_W];

   p_nosec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (access && !sec_sel) |-> (pslverr && prdata == '0));

   p_oob_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (access && in_win && int'(slot) >= WORDS) |-> (pslverr && prdata == '0));

   p_busy_lock_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ctrl_q));

endmodule

// File: rtl/fuse_shadow_reader.sv
module fuse_shadow_reader
   import fzr_pkg::*;
#(
   parameter int WORDS       = 32,
   parameter int DATA_W      = 32,
   parameter int FA_W        = 10,
   parameter int PADDR_W     = 12,
   parameter int SHADOW_BASE = 'h100,
   parameter int SETTLE_CYC  = 400
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sec_sel,
   input  logic               psel,
   input  logic               penable,
   input  logic               pwrite,
   input  logic [PADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0]  pwdata,
   output logic [DATA_W-1:0]  prdata,
   output logic               pready,
   output logic               pslverr,
   output logic               fz_csn,
   output logic               fz_strobe,
   output logic               fz_load,
   output logic               fz_pgm_en,
   output logic [FA_W-1:0]    fz_addr,
   input  logic [DATA_W-1:0]  fz_dout,
   output logic               rd_busy,
   output logic               rd_done
);
   localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   if (WORDS < 2 || WORDS > 64) begin : g_bad_words
      $error("fuse_shadow_reader: WORDS must be 2..64");
   end
   if (WORDS > (1 << FA_W)) begin : g_bad_fa
      $error("fuse_shadow_reader: FA_W too narrow for WORDS");
   end
   if (DATA_W < CTRL_ADDR_LSB + FA_W) begin : g_bad_dw
      $error("fuse_shadow_reader: DATA_W too narrow for control fields");
   end
   if (PADDR_W < 9 || (SHADOW_BASE % 256) != 0 || SHADOW_BASE == 0) begin : g_bad_map
      $error("fuse_shadow_reader: shadow window must be a nonzero 256-byte aligned base");
   end

   fz_pins_t          seq_pins, man_pins;
   logic [FA_W-1:0]   seq_addr, man_addr;
   logic              busy, cap_en;
   logic [IDX_W-1:0]  cap_idx, shadow_idx;
   logic [DATA_W-1:0] cap_data, shadow_data;

   fzr_read_seq #(
      .WORDS(WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W),
      .FA_W(FA_W), .SETTLE_CYC(SETTLE_CYC)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .fz_dout(fz_dout),
      .pins(seq_pins), .addr(seq_addr), .busy(busy), .done(rd_done),
      .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(cap_data)
   );

   fzr_shadow_buf #(.WORDS(WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cap_en), .wr_idx(cap_idx), .wr_data(cap_data),
      .rd_idx(shadow_idx), .rd_data(shadow_data)
   );

   fzr_apb_regs #(
      .WORDS(WORDS), .IDX_W(IDX_W), .DATA_W(DATA_W), .FA_W(FA_W),
      .PADDR_W(PADDR_W), .SHADOW_BASE(SHADOW_BASE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .sec_sel(sec_sel), .busy(busy),
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .fz_dout(fz_dout), .shadow_data(shadow_data), .shadow_idx(shadow_idx),
      .man_pins(man_pins), .man_addr(man_addr)
   );

   assign fz_csn    = busy ? seq_pins.csn    : man_pins.csn;
   assign fz_strobe = busy ? seq_pins.strobe : man_pins.strobe;
   assign fz_load   = busy ? seq_pins.load   : man_pins.load;
   assign fz_pgm_en = busy ? seq_pins.pgm_en : man_pins.pgm_en;
   assign fz_addr   = busy ? seq_addr        : man_addr;
   assign rd_busy   = busy;

   p_strobe_in_session_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_busy && fz_strobe) |-> (!fz_csn && fz_load && fz_pgm_en));

   p_addr_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |-> (int'(fz_addr) < WORDS));

   p_done_not_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |-> !rd_busy);

endmodule

// File: tb/sim_fuse_shadow_reader.sv
`timescale 1ns/1ps
module sim_fuse_shadow_reader;
   localparam int S      = 5;
   localparam int DW     = 32;
   localparam int AW     = 12;
   localparam int FAW    = 10;
   localparam logic [31:0] MASK = 32'h0000_FFCF;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sec_sel = 1'b1;
   logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [AW-1:0] paddr = '0;
   logic [DW-1:0] pwdata = '0;
   logic [DW-1:0] prdata;
   logic pready, pslverr;
   logic fz_csn, fz_strobe, fz_load, fz_pgm_en;
   logic [FAW-1:0] fz_addr;
   logic [DW-1:0] fz_dout;
   logic rd_busy, rd_done;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   function automatic logic [31:0] fuse_val(int a);
      logic [31:0] v;
      v = (32'(a) * 32'h9E37_79B1) ^ 32'h5A5A_0F0F ^ (32'(a) << 24);
      return v;
   endfunction

   assign fz_dout = (!fz_csn && fz_load && fz_pgm_en && fz_strobe)
                    ? ((int'(fz_addr) < 32) ? fuse_val(int'(fz_addr)) : 32'hBAD0_0000)
                    : 32'h0;

   fuse_shadow_reader #(.SETTLE_CYC(S)) u0 (
      .clk(clk), .rst_n(rst_n), .sec_sel(sec_sel),
      .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
      .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
      .fz_csn(fz_csn), .fz_strobe(fz_strobe), .fz_load(fz_load),
      .fz_pgm_en(fz_pgm_en), .fz_addr(fz_addr), .fz_dout(fz_dout),
      .rd_busy(rd_busy), .rd_done(rd_done)
   );

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // packed {csn,strobe,load,pgm,addr[9:0],busy,done}
   function automatic logic [15:0] exp_pins(int n);
      int ph, w, sub;
      ph = n / S;
      if (ph == 0)       return {4'b1000, 10'd0, 2'b10};
      else if (ph == 1)  return {4'b0011, 10'd0, 2'b10};
      else if (ph <= 97) begin
         w = (ph - 2) / 3; sub = (ph - 2) % 3;
         return {1'b0, (sub == 1), 2'b11, 10'(w), 2'b10};
      end
      else if (ph == 98) return {4'b0011, 10'd31, 2'b10};
      else if (ph == 99) return {4'b1011, 10'd31, 2'b10};
      else               return {4'b1000, 10'd0, 2'b01};
   endfunction

   function automatic string phase_req(int n);
      int ph;
      ph = n / S;
      if (ph == 0) return "R1";
      if (ph == 1) return "R2";
      if (ph <= 97) return "R3/R4";
      return "R5";
   endfunction

   task automatic apb_write(logic [AW-1:0] a, logic [31:0] d, output logic err);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      #1;
      err = pslverr;
      chk(pready == 1'b1, "R12 pready", 32'(pready), 32'd1);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      #1;
   endtask

   task automatic apb_read(logic [AW-1:0] a, output logic [31:0] d, output logic err);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      #1;
      d = prdata; err = pslverr;
      chk(pready == 1'b1, "R12 pready", 32'(pready), 32'd1);
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
      #1;
   endtask

   task automatic timeline();
      logic [15:0] act;
      for (int n = 0; n <= 100 * S + 3; n++) begin
         cyc = n;
         #1;
         act = {fz_csn, fz_strobe, fz_load, fz_pgm_en, fz_addr, rd_busy, rd_done};
         chk(act == exp_pins(n), phase_req(n), 32'(act), 32'(exp_pins(n)));
         @(negedge clk);
      end
   endtask

   initial begin : wdog
      #(150000 * 5);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] d, wv, saved;
      logic err;
      int a;
      void'($urandom(32'd20240611));

      repeat (3) @(negedge clk);
      #1;
      chk({fz_csn, fz_strobe, fz_load, fz_pgm_en, rd_busy, rd_done} == 6'b100010,
          "R1 in reset", 32'({fz_csn, fz_strobe, fz_load, fz_pgm_en, rd_busy, rd_done}),
          32'b100010);
      @(negedge clk);
      rst_n = 1'b1;

      fork
         timeline();
         begin
            wait (cyc == 30);
            apb_write(12'h000, 32'h0000_FFCE, err);   // R11: during busy
         end
      join

      // R11: busy-time write had no effect, control keeps reset value
      apb_read(12'h000, d, err);
      chk(d == 32'h1 && !err, "R11 ctrl after busy write", d, 32'h1);
      chk(fz_csn == 1'b1, "R11 csn pin", 32'(fz_csn), 32'd1);

      // R6: shadow contents, leakage words included
      for (int i = 0; i < 32; i++) begin
         apb_read(AW'(12'h100 + 4 * i), d, err);
         chk(d == fuse_val(i) && !err,
             (i >= 23 && i <= 25) ? "R6 leakage word" : "R6 shadow word", d, fuse_val(i));
      end

      // R7: out-of-range shadow slots
      for (int k = 0; k < 8; k++) begin
         a = 32 + int'($urandom_range(31, 0));
         apb_read(AW'(12'h100 + 4 * a), d, err);
         chk(d == 32'h0 && err, "R7 oob shadow", {d[30:0], err}, 32'h1);
      end
      apb_read(12'h17C, d, err);
      chk(d == fuse_val(31) && !err, "R7 last valid slot", d, fuse_val(31));

      // R9: manual control writes drive pins and read back masked
      for (int k = 0; k < 16; k++) begin
         wv = $urandom;
         apb_write(12'h000, wv, err);
         chk({fz_csn, fz_strobe, fz_load, fz_pgm_en, fz_addr} ==
             {wv[0], wv[1], wv[2], wv[3], wv[15:6]}, "R9 pins",
             32'({fz_csn, fz_strobe, fz_load, fz_pgm_en, fz_addr}),
             32'({wv[0], wv[1], wv[2], wv[3], wv[15:6]}));
         apb_read(12'h000, d, err);
         chk(d == (wv & MASK) && !err, "R9 readback", d, wv & MASK);
      end

      // R10: live data-out sampling
      for (int k = 0; k < 6; k++) begin
         a = int'($urandom_range(31, 0));
         if (k == 0) a = 24;
         apb_write(12'h000, 32'h0000_000E | (32'(a) << 6), err);
         apb_read(12'h004, d, err);
         chk(d == fuse_val(a) && !err, "R10 dout strobe high", d, fuse_val(a));
         apb_write(12'h000, 32'h0000_000C | (32'(a) << 6), err);
         apb_read(12'h004, d, err);
         chk(d == 32'h0, "R10 dout strobe low", d, 32'h0);
      end

      // R8: security select low
      apb_read(12'h000, saved, err);
      sec_sel = 1'b0;
      apb_write(12'h000, 32'h0000_0001, err);
      chk(err == 1'b1, "R8 write err", 32'(err), 32'd1);
      apb_read(12'h000, d, err);
      chk(d == 32'h0 && err, "R8 ctrl read", {d[30:0], err}, 32'h1);
      apb_read(12'h104, d, err);
      chk(d == 32'h0 && err, "R8 shadow read", {d[30:0], err}, 32'h1);
      sec_sel = 1'b1;
      apb_read(12'h000, d, err);
      chk(d == saved && !err, "R8 ctrl unchanged", d, saved);
      chk(fz_csn == saved[0] && fz_addr == saved[15:6], "R8 pins unchanged",
          32'({fz_csn, fz_addr}), 32'({saved[0], saved[15:6]}));

      // R5: done stays high
      chk(rd_done == 1'b1 && rd_busy == 1'b0, "R5 done sticky",
          32'({rd_busy, rd_done}), 32'b01);

      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule